// File: doc/BRIEF.md
# Split-Mode Precision Palette Unit

This block is the colour lookup stage of one display pipe. It stores 1024 entries, each an RGB triplet of 10-bit channels, and maps every incoming 10-bit RGB pixel through that table. A mode bit decides how the table is used. In plain mode the table is a single 1024-entry map, indexed by the full channel value. In split mode the lower 512 entries are a degamma curve and the upper 512 entries are a gamma curve, and each channel passes through both curves in turn.

Software reaches the table through a small register window. An index register holds the entry pointer, the mode bit and an auto-increment enable. A single data register then reads or writes the entry under the pointer, and with auto-increment on it steps the pointer after each access, so a whole curve loads as a stream of data writes. Three 16-bit clamp registers, one per channel, hold the output used when a channel reaches full scale between the two curves.

Top module: `split_lut_unit`

## Requirements
- R1: After reset the index register reads 0 (plain mode, auto-increment off, pointer 0) and all three clamp registers read 0xFFFF.
- R2: The index register (byte offset 0x00) keeps the mode in bit 31 (1 = split), the auto-increment enable in bit 15 and the pointer in bits 9:0; on read every other bit is 0, whatever was written there.
- R3: A data write (offset 0x04) stores bits 29:0 of the word in the entry under the pointer; with auto-increment off, the pointer does not move on data accesses.
- R4: With auto-increment on, each data write advances the pointer by one after storing, and the pointer wraps from 1023 to 0.
- R5: A data read returns the entry under the pointer, zero-extended, one cycle after the request; with auto-increment on, the read advances the pointer too.
- R6: A data word packs red in bits 29:20, green in bits 19:10 and blue in bits 9:0; bits 31:30 are ignored on write and read as 0.
- R7: Writing 0 to the index register clears the mode bit, the auto-increment bit and the pointer.
- R8: The clamp registers for red, green and blue sit at offsets 0x10, 0x14 and 0x18; each keeps the low 16 bits of a write and reads back zero-extended.
- R9: In split mode each channel value v first reads degamma entry v[9:1] (entries 0 to 511), then the result d reads gamma entry 512 + d[9:1]; the result appears on the pixel output two clock edges after the input is sampled.
- R10: In split mode a degamma result equal to 1023 bypasses the gamma half, and that channel outputs bits 15:6 of its clamp register.
- R11: In plain mode each channel value v reads entry v directly from the full 1024-entry table and no clamp applies, including for v = 1023.
- R12: The output valid flag follows the input valid flag exactly two clock edges later and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| pix_valid | input | 1 | Input pixel valid |
| pix_in | input | 30 | Input pixel, red 29:20, green 19:10, blue 9:0 |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out | output | 30 | Output pixel, same packing as pix_in |

## Verification
The table is filled with random words so that each channel of each entry differs, and random pixels are then pushed through in split mode and in plain mode; a crossed channel field, a wrong half or a wrong index slice shows as a mismatch against the bench's own table model. Directed pixels aim at degamma entries set to full scale on one or all channels, which separates the clamp bypass from an ordinary gamma lookup and checks the clamp bit slice. Plain-mode pixels at code 1023 tell plain mode from split mode at the one value where a clamp would wrongly apply. Pointer sequencing is tried with and without auto-increment, on reads as well as writes, and across the wrap from 1023 to 0.

// File: rtl/split_lut_pkg.sv
`timescale 1ns/1ps
package split_lut_pkg;

    localparam int NCH      = 3;
    localparam int MODE_BIT = 31;
    localparam int AINC_BIT = 15;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 5;

    localparam logic [ADDR_W-1:0] OFF_INDEX   = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_DATA    = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_CLAMP_R = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_CLAMP_G = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_CLAMP_B = 5'h18;

    // channel positions inside packed triplets: 2 = red, 1 = green, 0 = blue
    localparam int CH_RED   = 2;
    localparam int CH_GREEN = 1;
    localparam int CH_BLUE  = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_INDEX,
        SEL_DATA,
        SEL_CLAMP_R,
        SEL_CLAMP_G,
        SEL_CLAMP_B
    } reg_sel_e;

    typedef enum logic {
        MODE_PLAIN = 1'b0,
        MODE_SPLIT = 1'b1
    } lut_mode_e;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        case (a)
            OFF_INDEX:   return SEL_INDEX;
            OFF_DATA:    return SEL_DATA;
            OFF_CLAMP_R: return SEL_CLAMP_R;
            OFF_CLAMP_G: return SEL_CLAMP_G;
            OFF_CLAMP_B: return SEL_CLAMP_B;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic reg_sel_e clamp_sel(int ch);
        case (ch)
            CH_RED:   return SEL_CLAMP_R;
            CH_GREEN: return SEL_CLAMP_G;
            default:  return SEL_CLAMP_B;
        endcase
    endfunction

endpackage

// File: rtl/lut_regs.sv
`timescale 1ns/1ps
module lut_regs
    import split_lut_pkg::*;
#(
    parameter int IDX_W   = 10,
    parameter int CH_W    = 10,
    parameter int CLAMP_W = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               reg_wr,
    input  logic                               reg_rd,
    input  logic [ADDR_W-1:0]                  reg_addr,
    input  logic [REG_W-1:0]                   reg_wdata,
    output logic [REG_W-1:0]                   reg_rdata,
    output logic                               tbl_we,
    output logic [IDX_W-1:0]                   tbl_addr,
    output logic [NCH-1:0][CH_W-1:0]           tbl_wdata,
    input  logic [NCH-1:0][CH_W-1:0]           tbl_rdata,
    output lut_mode_e                          mode,
    output logic [NCH-1:0][CLAMP_W-1:0]        clamp
);

    localparam int WORD_W = NCH * CH_W;

    reg_sel_e          sel;
    logic              idx_wr;
    logic              data_wr;
    logic              data_rd;
    logic              ainc;
    logic [IDX_W-1:0]  idx;
    logic [REG_W-1:0]  rd_word;
    logic [NCH-1:0]    clamp_hit;
    logic              unused_wbits;

    assign sel     = decode_addr(reg_addr);
    assign idx_wr  = reg_wr && (sel == SEL_INDEX);
    assign data_wr = reg_wr && (sel == SEL_DATA);
    assign data_rd = reg_rd && !reg_wr && (sel == SEL_DATA);

    assign tbl_we    = data_wr;
    assign tbl_addr  = idx;
    assign tbl_wdata = reg_wdata[WORD_W-1:0];

    assign unused_wbits = ^reg_wdata[REG_W-2:WORD_W];

    // pointer, mode and auto-increment sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            mode <= MODE_PLAIN;
            ainc <= 1'b0;
        end else if (idx_wr) begin
            idx  <= reg_wdata[IDX_W-1:0];
            mode <= lut_mode_e'(reg_wdata[MODE_BIT]);
            ainc <= reg_wdata[AINC_BIT];
        end else if ((data_wr || data_rd) && ainc) begin
            idx <= idx + 1'b1;
        end
    end

    // per-channel clamp registers
    for (genvar c = 0; c < NCH; c++) begin : g_clamp
        assign clamp_hit[c] = reg_wr && (sel == clamp_sel(c));
        always_ff @(posedge clk) begin
            if (rst) begin
                clamp[c] <= '1;
            end else if (clamp_hit[c]) begin
                clamp[c] <= reg_wdata[CLAMP_W-1:0];
            end
        end
    end

    // read mux
    always_comb begin
        rd_word = '0;
        case (sel)
            SEL_INDEX: begin
                rd_word[MODE_BIT]    = mode;
                rd_word[AINC_BIT]    = ainc;
                rd_word[IDX_W-1:0]   = idx;
            end
            SEL_DATA:    rd_word[WORD_W-1:0]  = tbl_rdata;
            SEL_CLAMP_R: rd_word[CLAMP_W-1:0] = clamp[CH_RED];
            SEL_CLAMP_G: rd_word[CLAMP_W-1:0] = clamp[CH_GREEN];
            SEL_CLAMP_B: rd_word[CLAMP_W-1:0] = clamp[CH_BLUE];
            default:     rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_word;
        end
    end

    // R4
    idx_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (ainc && (data_wr || data_rd) && !idx_wr) |=> (idx == IDX_W'($past(idx) + 1'b1)));

    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ainc && !idx_wr) |=> $stable(idx));

    // R7
    idx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (idx_wr && (reg_wdata == '0)) |=> (mode == MODE_PLAIN && !ainc && idx == '0));

    // R1
    clamp_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (clamp == '1));

endmodule

// File: rtl/lut_bank.sv
`timescale 1ns/1ps
module lut_bank #(
    parameter int IDX_W = 10,
    parameter int CH_W  = 10
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [CH_W-1:0]  wdata,
    input  logic [IDX_W-1:0] cpu_addr,
    output logic [CH_W-1:0]  cpu_data,
    input  logic [IDX_W-1:0] deg_addr,
    output logic [CH_W-1:0]  deg_data,
    input  logic [IDX_W-1:0] gam_addr,
    output logic [CH_W-1:0]  gam_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [CH_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign cpu_data = mem[cpu_addr];
    assign deg_data = mem[deg_addr];
    assign gam_data = mem[gam_addr];

endmodule

// File: rtl/lut_pipe.sv
`timescale 1ns/1ps
module lut_pipe
    import split_lut_pkg::*;
#(
    parameter int IDX_W   = 10,
    parameter int CH_W    = 10,
    parameter int CLAMP_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  lut_mode_e                     mode,
    input  logic [NCH-1:0][CLAMP_W-1:0]   clamp,
    input  logic                          pix_valid,
    input  logic [NCH-1:0][CH_W-1:0]      pix_in,
    output logic [NCH-1:0][IDX_W-1:0]     deg_addr,
    input  logic [NCH-1:0][CH_W-1:0]      deg_data,
    output logic [NCH-1:0][IDX_W-1:0]     gam_addr,
    input  logic [NCH-1:0][CH_W-1:0]      gam_data,
    output logic                          out_valid,
    output logic [NCH-1:0][CH_W-1:0]      pix_out
);

    localparam int HALF_W = IDX_W - 1;
    localparam logic [CH_W-1:0] FULL = '1;

    logic                      s1_valid;
    lut_mode_e                 s1_mode;
    logic [NCH-1:0][CH_W-1:0]  s1_val;
    logic [NCH-1:0][CH_W-1:0]  s2_next;
    logic                      unused_clamp;

    always_comb begin
        unused_clamp = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            unused_clamp = unused_clamp ^ (^clamp[c][CLAMP_W-CH_W-1:0]);
        end
    end

    // stage 1: degamma half (split) or full table (plain)
    for (genvar c = 0; c < NCH; c++) begin : g_stage1
        assign deg_addr[c] = (mode == MODE_SPLIT)
            ? {1'b0, pix_in[c][CH_W-1 -: HALF_W]}
            : pix_in[c][CH_W-1 -: IDX_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_mode  <= MODE_PLAIN;
            s1_val   <= '0;
        end else begin
            s1_valid <= pix_valid;
            s1_mode  <= mode;
            s1_val   <= deg_data;
        end
    end

    // stage 2: gamma half with full-scale clamp
    for (genvar c = 0; c < NCH; c++) begin : g_stage2
        assign gam_addr[c] = {1'b1, s1_val[c][CH_W-1 -: HALF_W]};
        always_comb begin
            if (s1_mode == MODE_PLAIN) begin
                s2_next[c] = s1_val[c];
            end else if (s1_val[c] == FULL) begin
                s2_next[c] = clamp[c][CLAMP_W-1 -: CH_W];
            end else begin
                s2_next[c] = gam_data[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            pix_out   <= '0;
        end else begin
            out_valid <= s1_valid;
            pix_out   <= s2_next;
        end
    end

    // R12
    stage1_valid_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> s1_valid);

    // R12
    stage2_valid_chk: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);

    // R12
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!pix_valid && !s1_valid) |=> ##1 !out_valid);

endmodule

// File: rtl/split_lut_unit.sv
`timescale 1ns/1ps
module split_lut_unit
    import split_lut_pkg::*;
#(
    parameter int IDX_W   = 10,
    parameter int CH_W    = 10,
    parameter int CLAMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [4:0]              reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic                    pix_valid,
    input  logic [NCH*CH_W-1:0]     pix_in,
    output logic                    pix_out_valid,
    output logic [NCH*CH_W-1:0]     pix_out
);

    logic                          tbl_we;
    logic [IDX_W-1:0]              tbl_addr;
    logic [NCH-1:0][CH_W-1:0]      tbl_wdata;
    logic [NCH-1:0][CH_W-1:0]      tbl_rdata;
    lut_mode_e                     mode;
    logic [NCH-1:0][CLAMP_W-1:0]   clamp;
    logic [NCH-1:0][IDX_W-1:0]     deg_addr;
    logic [NCH-1:0][CH_W-1:0]      deg_data;
    logic [NCH-1:0][IDX_W-1:0]     gam_addr;
    logic [NCH-1:0][CH_W-1:0]      gam_data;
    logic [NCH-1:0][CH_W-1:0]      pix_in_a;
    logic [NCH-1:0][CH_W-1:0]      pix_out_a;

    assign pix_in_a = pix_in;
    assign pix_out  = pix_out_a;

    lut_regs #(
        .IDX_W   (IDX_W),
        .CH_W    (CH_W),
        .CLAMP_W (CLAMP_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tbl_we    (tbl_we),
        .tbl_addr  (tbl_addr),
        .tbl_wdata (tbl_wdata),
        .tbl_rdata (tbl_rdata),
        .mode      (mode),
        .clamp     (clamp)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_bank
        lut_bank #(
            .IDX_W (IDX_W),
            .CH_W  (CH_W)
        ) u_bank (
            .clk      (clk),
            .we       (tbl_we),
            .waddr    (tbl_addr),
            .wdata    (tbl_wdata[c]),
            .cpu_addr (tbl_addr),
            .cpu_data (tbl_rdata[c]),
            .deg_addr (deg_addr[c]),
            .deg_data (deg_data[c]),
            .gam_addr (gam_addr[c]),
            .gam_data (gam_data[c])
        );
    end

    lut_pipe #(
        .IDX_W   (IDX_W),
        .CH_W    (CH_W),
        .CLAMP_W (CLAMP_W)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .clamp     (clamp),
        .pix_valid (pix_valid),
        .pix_in    (pix_in_a),
        .deg_addr  (deg_addr),
        .deg_data  (deg_data),
        .gam_addr  (gam_addr),
        .gam_data  (gam_data),
        .out_valid (pix_out_valid),
        .pix_out   (pix_out_a)
    );

endmodule

// File: tb/split_lut_unit_bench.sv
`timescale 1ns/1ps
module split_lut_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_valid = 1'b0;
    logic [29:0] pix_in = '0;
    logic        pix_out_valid;
    logic [29:0] pix_out;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [29:0] m_tbl [1024];
    int          m_idx = 0;
    bit          m_split = 0;
    bit          m_ainc = 0;
    logic [15:0] m_clamp [3];

    always #2.5 clk = ~clk;

    split_lut_unit u_split_lut_unit (
        .clk           (clk),
        .rst           (rst),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .pix_valid     (pix_valid),
        .pix_in        (pix_in),
        .pix_out_valid (pix_out_valid),
        .pix_out       (pix_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic set_index(input logic [31:0] d);
        bus_wr(5'h00, d);
        m_idx   = int'(d[9:0]);
        m_split = d[31];
        m_ainc  = d[15];
    endtask

    task automatic data_write(input logic [31:0] d);
        bus_wr(5'h04, d);
        m_tbl[m_idx] = d[29:0];
        if (m_ainc) m_idx = (m_idx + 1) % 1024;
    endtask

    task automatic data_read_chk(input string req);
        logic [31:0] v;
        bus_rd(5'h04, v);
        chk(req, v, {2'b00, m_tbl[m_idx]});
        if (m_ainc) m_idx = (m_idx + 1) % 1024;
    endtask

    function automatic logic [4:0] clamp_addr(int c);
        return 5'(8'h18 - 8'(4 * c));
    endfunction

    function automatic logic [29:0] exp_pix(logic [29:0] p, bit split);
        logic [29:0] r;
        logic [9:0]  v;
        logic [9:0]  d;
        r = '0;
        for (int c = 0; c < 3; c++) begin
            v = p[c*10 +: 10];
            if (!split) begin
                r[c*10 +: 10] = m_tbl[v][c*10 +: 10];
            end else begin
                d = m_tbl[{1'b0, v[9:1]}][c*10 +: 10];
                if (d == 10'h3FF) r[c*10 +: 10] = m_clamp[c][15:6];
                else              r[c*10 +: 10] = m_tbl[{1'b1, d[9:1]}][c*10 +: 10];
            end
        end
        return r;
    endfunction

    task automatic send_pix(input string req, input logic [29:0] p);
        logic [29:0] e;
        e = exp_pix(p, m_split);
        @(negedge clk);
        pix_valid = 1'b1; pix_in = p;
        @(negedge clk);
        pix_valid = 1'b0;
        chk("R12 early", {31'b0, pix_out_valid}, 32'd0);
        @(negedge clk);
        chk("R12 valid", {31'b0, pix_out_valid}, 32'd1);
        chk(req, {2'b00, pix_out}, {2'b00, e});
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [29:0] a_word;
        logic [29:0] b_word;
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) m_tbl[i] = '0;
        for (int c = 0; c < 3; c++) m_clamp[c] = 16'hFFFF;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R12 reset", {31'b0, pix_out_valid}, 32'd0);
        bus_rd(5'h00, v); chk("R1 index", v, 32'h0);
        for (int c = 0; c < 3; c++) begin
            bus_rd(clamp_addr(c), v); chk("R1 clamp", v, 32'h0000FFFF);
        end

        // R2 field layout
        set_index(32'h8000_8123);
        bus_rd(5'h00, v); chk("R2 fields", v, 32'h8000_8123);
        set_index(32'hFFFF_FFFF);
        bus_rd(5'h00, v); chk("R2 masked", v, 32'h8000_83FF);

        // R7 clear
        set_index(32'h0);
        bus_rd(5'h00, v); chk("R7 cleared", v, 32'h0);

        // R3 / R6 single write without increment
        set_index(32'h0000_0005);
        data_write(32'hC000_0000 | {2'b00, 10'h155, 10'h2AA, 10'h0F0});
        data_read_chk("R6 packing");
        bus_rd(5'h00, v); chk("R3 pointer held", v, 32'h0000_0005);

        // R4 full random load with wrap
        set_index(32'h8000_8000);
        for (int i = 0; i < 1024; i++) data_write($urandom);
        bus_rd(5'h00, v); chk("R4 wrapped", v, 32'h8000_8000);

        // R4 / R5 directed wrap on write and read
        a_word = 30'($urandom); b_word = 30'($urandom);
        set_index(32'h8000_83FF);
        data_write({2'b00, a_word});
        data_write({2'b00, b_word});
        bus_rd(5'h00, v); chk("R4 wrap point", v, 32'h8000_8001);
        set_index(32'h8000_83FF);
        data_read_chk("R5 read 1023");
        data_read_chk("R5 read 0");
        bus_rd(5'h00, v); chk("R5 read advance", v, 32'h8000_8001);
        set_index(32'h8000_0010);
        data_read_chk("R5 no advance");
        data_read_chk("R5 no advance");

        // R8 clamp registers
        for (int c = 0; c < 3; c++) begin
            v = $urandom;
            bus_wr(clamp_addr(c), v);
            m_clamp[c] = v[15:0];
            bus_rd(clamp_addr(c), v); chk("R8 clamp", v, {16'h0, m_clamp[c]});
        end

        // R10 directed full-scale degamma entries
        set_index(32'h8000_0007);
        data_write({2'b00, 10'h3FF, 10'h3FF, 10'h3FF});
        set_index(32'h8000_0008);
        data_write({2'b00, 10'h3FF, 10'h123, 10'h200});
        send_pix("R10 all clamp", {10'd14, 10'd15, 10'd14});
        send_pix("R10 red clamp", {10'd16, 10'd17, 10'd16});

        // R9 split mode boundaries and random
        send_pix("R9 zero", 30'h0);
        send_pix("R9 max", {10'h3FF, 10'h3FF, 10'h3FF});
        for (int i = 0; i < 80; i++) send_pix("R9 random", 30'($urandom));

        // R11 plain mode
        set_index(32'h0000_0000);
        send_pix("R11 max code", {10'h3FF, 10'h3FF, 10'h3FF});
        send_pix("R11 entry 7", {10'd7, 10'd7, 10'd7});
        for (int i = 0; i < 60; i++) send_pix("R11 random", 30'($urandom));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule